// File: doc/BRIEF.md
# Timer slave mode controller

This block is an up-counting timer whose count can be driven by an external trigger instead of, or alongside, its own clock. A trigger multiplexer picks one of seven sources: four internal trigger lines from other timers, a pulse on either edge of the raw channel-1 input, the filtered channel-1 input, and the filtered channel-2 input. A mode field then decides what the chosen trigger does to the counter. It can restart the counter, gate it, start it, or clock it.

Software programs the block through a small write port with three word addresses: control, slave configuration and auto-reload. The counter wraps to zero at the active reload value and pulses `update_o` when it does. That reload value is a shadow copy, and it takes the written value only on an update event. A trigger-output pulse lets downstream timers follow restart and start events. The optional synchronization delay holds back this timer's own reaction by one clock, so that it acts in the same cycle as the timers that listen to its trigger output.

Top module: `tmr_slave_ctl`

## Requirements
- R1: Reset state. After reset the count is 0, `update_o` and `trig_o` are low, the counter enable is clear, the mode is 0, the source select is 0 and the active reload value is all ones.
- R2: Register map and field split. Address 0 bit 0 is the counter enable. At address 1, the mode is {bit 16, bits [2:0]}, the source select is {bits [18:17], bits [6:4]} and bit 7 is the sync-delay enable. Address 2 bits [15:0] are the preload of the reload value. Mode 12 behaves as mode 0, and select 8 picks no source.
- R3: Trigger select. Values 0 to 3 pick internal lines 0 to 3, value 4 picks the channel-1 edge pulse, 5 picks filtered channel 1 and 6 picks filtered channel 2. Values 7 to 31 give a trigger that is always low. A source that is not selected has no effect on the count.
- R4: The channel-1 edge source is high for one cycle after each rising or falling edge of `ch1_i`, compared with its value at the previous clock.
- R5: Modes 0 to 3 and 8 to 15 ignore the trigger. The counter advances by one every clock while the enable is set.
- R6: Mode 4 (restart). With the enable set, the counter advances every clock. A trigger rising edge sets the count to 0, pulses `update_o` and loads the preload into the active reload value.
- R7: Mode 5 (gated). The counter advances by one on each clock where the enable is set and the trigger is high. Otherwise it holds.
- R8: Mode 6 (start). A trigger rising edge sets the counter enable without changing the count. Counting begins on the following clock.
- R9: Mode 7 (external clock). With the enable set, the counter advances by one on each trigger rising edge and holds otherwise.
- R10: Wrap and reload. An advance from the active reload value gives 0 and pulses `update_o` for one cycle. The active reload value changes only on an update event, so a write to the preload has no effect on wrapping until the next update.
- R11: Sync delay. When bit 7 is set, every trigger action (restart, start, clock, gate level) occurs one clock later than without it. `trig_o` pulses for one cycle in the cycle after any trigger rising edge in modes 4 and 6, whether or not the delay is enabled.
- R12: A trigger rising edge is the trigger being high while it was low at the previous clock. A trigger held high counts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 19 | Register write data |
| itrig_i | input | 4 | Internal trigger lines |
| ch1_i | input | 1 | Raw channel-1 input, synchronous |
| ch1_filt_i | input | 1 | Filtered channel-1 input |
| ch2_filt_i | input | 1 | Filtered channel-2 input |
| count_o | output | 16 | Counter value |
| update_o | output | 1 | Update event pulse |
| trig_o | output | 1 | Trigger output pulse |

## Verification
The assertions assume that every trigger source and register write is synchronous to `clk_i` and stable around the rising edge. They also assume that the mode and source select are not rewritten in the same cycle as a trigger edge they should act on. The bench changes all inputs on the falling edge only. It programs the configuration after a reset and before it applies any trigger activity. The only exception is the start-mode test, which rewrites the mode while no trigger edge is in flight.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W      = 19;
  localparam int ADDR_W     = 2;
  localparam int SEL_W      = 5;
  localparam int MODE_W     = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SCFG = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_ARR  = 2'd2;

  localparam int BIT_CEN     = 0;
  localparam int BIT_MSYNC   = 7;
  localparam int BIT_MODE_HI = 16;
  localparam int SEL_HI_LSB  = 17;
  localparam int SEL_LO_LSB  = 4;

  typedef enum logic [MODE_W-1:0] {
    SM_OFF    = 4'd0,
    SM_RESET  = 4'd4,
    SM_GATED  = 4'd5,
    SM_START  = 4'd6,
    SM_EXTCLK = 4'd7
  } slave_mode_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [SEL_W-1:0]  sel;
    logic              msync;
  } slave_cfg_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter logic [CNT_W-1:0] ARR_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              cen_set_i,
  input  logic              upd_i,
  output logic              cen_o,
  output slave_cfg_t        cfg_o,
  output logic [CNT_W-1:0]  arr_o
);
  logic [CNT_W-1:0] arr_pre_q, arr_act_q;
  logic             cen_q;
  slave_cfg_t       cfg_q;
  slave_cfg_t       cfg_d;

  always_comb begin
    cfg_d.mode  = {wdata_i[BIT_MODE_HI], wdata_i[2:0]};
    cfg_d.sel   = {wdata_i[SEL_HI_LSB+1:SEL_HI_LSB], wdata_i[SEL_LO_LSB+2:SEL_LO_LSB]};
    cfg_d.msync = wdata_i[BIT_MSYNC];
  end

  // trigger start wins over a concurrent software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q <= 1'b0;
    end else if (we_i && addr_i == ADDR_CTRL) begin
      cen_q <= wdata_i[BIT_CEN] | cen_set_i;
    end else begin
      cen_q <= cen_q | cen_set_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i && addr_i == ADDR_SCFG) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_pre_q <= ARR_RST;
    end else if (we_i && addr_i == ADDR_ARR) begin
      arr_pre_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_act_q <= ARR_RST;
    end else if (upd_i) begin
      arr_act_q <= arr_pre_q;
    end
  end

  assign cen_o = cen_q;
  assign cfg_o = cfg_q;
  assign arr_o = arr_act_q;

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(arr_o)) else $error("shadow reload changed without update"); // R10

  AST_START_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_set_i |=> cen_o) else $error("start event did not set enable"); // R8
endmodule

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel
  import tmr_pkg::*;
#(
  parameter int N_ITR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ITR-1:0] itrig_i,
  input  logic             ch1_i,
  input  logic             ch1_filt_i,
  input  logic             ch2_filt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             msync_i,
  output logic             lvl_o,
  output logic             evt_o,
  output logic             rise_o
);
  localparam int N_SRC = N_ITR + 3;

  logic             ch1_q;
  logic             ch1_edge;
  logic [N_SRC-1:0] src;
  logic             trgi, trgi_q;
  logic             rise, rise_q;

  assign ch1_edge = ch1_i ^ ch1_q;
  assign src      = {ch2_filt_i, ch1_filt_i, ch1_edge, itrig_i};

  always_comb begin
    trgi = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel_i == SEL_W'(i)) trgi = src[i];
    end
  end

  assign rise = trgi & ~trgi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch1_q  <= 1'b0;
      trgi_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      ch1_q  <= ch1_i;
      trgi_q <= trgi;
      rise_q <= rise;
    end
  end

  assign lvl_o  = msync_i ? trgi_q : trgi;
  assign evt_o  = msync_i ? rise_q : rise;
  assign rise_o = rise;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o) else $error("edge held two cycles"); // R12

  AST_MSYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msync_i && evt_o) |-> $past(rise_o)) else $error("delayed event without prior edge"); // R11

  AST_SEL_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i >= SEL_W'(N_SRC) && !msync_i) |-> !evt_o) else $error("event from unused select"); // R3
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              cen_i,
  input  logic              lvl_i,
  input  logic              evt_i,
  input  logic              rise_i,
  input  logic [CNT_W-1:0]  arr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              upd_o,
  output logic              upd_now_o,
  output logic              cen_set_o,
  output logic              trg_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             upd_q, trg_q;
  logic             tick, clr, wrap;

  always_comb begin
    tick      = 1'b0;
    clr       = 1'b0;
    cen_set_o = 1'b0;
    case (mode_i)
      SM_RESET: begin
        tick = cen_i;
        clr  = evt_i;
      end
      SM_GATED:  tick = cen_i & lvl_i;
      SM_START: begin
        tick      = cen_i;
        cen_set_o = evt_i;
      end
      SM_EXTCLK: tick = cen_i & evt_i;
      default:   tick = cen_i;
    endcase
  end

  assign wrap      = tick && (cnt_q == arr_i);
  assign upd_now_o = clr | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr || wrap) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // trigger out follows the undelayed edge so listeners line up with a delayed self
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      trg_q <= 1'b0;
    end else begin
      upd_q <= upd_now_o;
      trg_q <= rise_i && (mode_i == SM_RESET || mode_i == SM_START);
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;
  assign trg_o = trg_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= arr_i) else $error("count above reload"); // R10

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) + 1'b1 || cnt_o == '0))
    else $error("count jumped"); // R10

  AST_UPD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> cnt_o == '0) else $error("update without zero count"); // R6

  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_GATED && !lvl_i) |=> $stable(cnt_o)) else $error("gated count moved"); // R7

  AST_EXT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_EXTCLK && !evt_i) |=> $stable(cnt_o)) else $error("ext clock count moved"); // R9

  AST_TRIG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trg_o |=> !trg_o) else $error("trigger out longer than one cycle"); // R11
endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
  import tmr_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter int               N_ITR   = 4,
  parameter logic [CNT_W-1:0] ARR_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic [N_ITR-1:0]  itrig_i,
  input  logic              ch1_i,
  input  logic              ch1_filt_i,
  input  logic              ch2_filt_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              update_o,
  output logic              trig_o
);
  slave_cfg_t       cfg;
  logic             cen, cen_set, upd_now;
  logic             lvl, evt, rise;
  logic [CNT_W-1:0] arr;

  tmr_regs #(.CNT_W(CNT_W), .ARR_RST(ARR_RST)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .cen_set_i (cen_set),
    .upd_i     (upd_now),
    .cen_o     (cen),
    .cfg_o     (cfg),
    .arr_o     (arr)
  );

  tmr_trig_sel #(.N_ITR(N_ITR)) u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .itrig_i    (itrig_i),
    .ch1_i      (ch1_i),
    .ch1_filt_i (ch1_filt_i),
    .ch2_filt_i (ch2_filt_i),
    .sel_i      (cfg.sel),
    .msync_i    (cfg.msync),
    .lvl_o      (lvl),
    .evt_o      (evt),
    .rise_o     (rise)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (cfg.mode),
    .cen_i     (cen),
    .lvl_i     (lvl),
    .evt_i     (evt),
    .rise_i    (rise),
    .arr_i     (arr),
    .cnt_o     (count_o),
    .upd_o     (update_o),
    .upd_now_o (upd_now),
    .cen_set_o (cen_set),
    .trg_o     (trig_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (count_o == '0 && !update_o && !trig_o)) else $error("not idle after reset"); // R1
endmodule

// File: tb/sim_tmr_slave_ctl.sv
`timescale 1ns/1ps
module sim_tmr_slave_ctl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [18:0] wdata = '0;
  logic [3:0]  itrig = '0;
  logic        ch1 = 1'b0, ch1f = 1'b0, ch2f = 1'b0;
  logic [15:0] count;
  logic        upd, trg;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  tmr_slave_ctl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .itrig_i(itrig), .ch1_i(ch1), .ch1_filt_i(ch1f), .ch2_filt_i(ch2f),
    .count_o(count), .update_o(upd), .trig_o(trg)
  );

  // {req id, mode, sel, drive index, enable, pulses, expected count}
  localparam logic [40:0] VEC [15] = '{
    {4'd5,  4'd0,  5'd0, 3'd0, 1'b1, 8'd3, 16'd6},  // R5 disabled, counts on clock
    {4'd5,  4'd0,  5'd0, 3'd0, 1'b0, 8'd3, 16'd0},  // R5 enable clear
    {4'd6,  4'd4,  5'd0, 3'd0, 1'b1, 8'd3, 16'd1},  // R6 restart on each edge
    {4'd7,  4'd5,  5'd1, 3'd1, 1'b1, 8'd3, 16'd3},  // R7 gated by itrig1
    {4'd8,  4'd6,  5'd2, 3'd2, 1'b0, 8'd3, 16'd5},  // R8 started by itrig2
    {4'd9,  4'd7,  5'd3, 3'd3, 1'b1, 8'd3, 16'd3},  // R9 clocked by itrig3
    {4'd3,  4'd7,  5'd5, 3'd5, 1'b1, 8'd3, 16'd3},  // R3 filtered ch1
    {4'd3,  4'd7,  5'd6, 3'd6, 1'b1, 8'd3, 16'd3},  // R3 filtered ch2
    {4'd4,  4'd5,  5'd4, 3'd4, 1'b1, 8'd3, 16'd6},  // R4 gated by ch1 edges
    {4'd3,  4'd7,  5'd0, 3'd1, 1'b1, 8'd3, 16'd0},  // R3 unselected source
    {4'd5,  4'd2,  5'd0, 3'd0, 1'b1, 8'd3, 16'd6},  // R5 unlisted mode
    {4'd2,  4'd12, 5'd0, 3'd0, 1'b1, 8'd3, 16'd6},  // R2 mode high bit
    {4'd2,  4'd7,  5'd8, 3'd0, 1'b1, 8'd3, 16'd0},  // R2 select high bits
    {4'd3,  4'd7,  5'd7, 3'd0, 1'b1, 8'd3, 16'd0},  // R3 select 7
    {4'd12, 4'd7,  5'd4, 3'd4, 1'b1, 8'd3, 16'd1}   // R12 held-high trigger is one edge
  };

  function automatic string req_name(input logic [3:0] id);
    case (id)
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [18:0] scfg(input logic [3:0] m, input logic [4:0] s, input logic ms);
    logic [18:0] w;
    w = '0;
    w[2:0]   = m[2:0];
    w[6:4]   = s[2:0];
    w[7]     = ms;
    w[16]    = m[3];
    w[18:17] = s[4:3];
    return w;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [18:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic do_reset;
    rst_ni = 1'b0; itrig = '0; ch1 = 0; ch1f = 0; ch2f = 0; we = 0;
    tick(); tick();
    rst_ni = 1'b1;
  endtask

  task automatic set_src(input logic [2:0] d, input logic v);
    case (d)
      3'd4:    ch1 = v;
      3'd5:    ch1f = v;
      3'd6:    ch2f = v;
      default: itrig[d[1:0]] = v;
    endcase
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    tick();
    do_reset();
    chk("R1 count", count, 0);
    chk("R1 update", upd, 0);
    chk("R1 trig", trg, 0);

    for (int v = 0; v < 15; v++) begin
      do_reset();
      wr(2'd1, scfg(VEC[v][36:33], VEC[v][32:28], 1'b0));
      wr(2'd0, {18'd0, VEC[v][24]});
      for (int p = 0; p < int'(VEC[v][23:16]); p++) begin
        set_src(VEC[v][27:25], 1'b1);
        tick();
        set_src(VEC[v][27:25], 1'b0);
        tick();
      end
      chk(req_name(VEC[v][40:37]), count, int'(VEC[v][15:0]));
    end

    // R10 preload does not act before an update
    do_reset();
    wr(2'd2, 19'd2);
    wr(2'd0, 19'd1);
    repeat (4) tick();
    chk("R10 no early reload", count, 4);

    // R6 restart loads reload, then R10 wrap at new value
    do_reset();
    wr(2'd2, 19'd3);
    wr(2'd1, scfg(4'd4, 5'd0, 1'b0));
    wr(2'd0, 19'd1);
    repeat (2) tick();
    chk("R6 pre count", count, 2);
    itrig[0] = 1'b1;
    tick();
    chk("R6 cleared", count, 0);
    chk("R6 update", upd, 1);
    chk("R11 trig out", trg, 1);
    itrig[0] = 1'b0;
    tick();
    chk("R11 trig one cycle", trg, 0);
    tick(); tick();
    chk("R10 at reload", count, 3);
    chk("R10 no update", upd, 0);
    tick();
    chk("R10 wrap", count, 0);
    chk("R10 wrap update", upd, 1);

    // R11 sync delay
    do_reset();
    wr(2'd1, scfg(4'd4, 5'd0, 1'b1));
    wr(2'd0, 19'd1);
    repeat (2) tick();
    itrig[0] = 1'b1;
    tick();
    chk("R11 not yet cleared", count, 3);
    chk("R11 trig undelayed", trg, 1);
    itrig[0] = 1'b0;
    tick();
    chk("R11 delayed clear", count, 0);
    chk("R11 delayed update", upd, 1);

    // R8 start keeps count
    do_reset();
    wr(2'd0, 19'd1);
    repeat (3) tick();
    wr(2'd0, 19'd0);
    wr(2'd1, scfg(4'd6, 5'd0, 1'b0));
    chk("R8 held", count, 4);
    itrig[0] = 1'b1;
    tick();
    chk("R8 no clear", count, 4);
    chk("R8 trig out", trg, 1);
    itrig[0] = 1'b0;
    tick();
    chk("R8 started", count, 5);

    summary();
    $finish;
  end
endmodule